// File: doc/BRIEF.md
# Memory-Operand ALU Instruction Sequencer

This block is the control sequencer for accumulator arithmetic and logic instructions that take their second operand from memory. It fetches bytes from a byte-wide read port, one clock per T-state, and decodes them. It then works out the operand address and reads the operand. Finally it hands the operation code and the operand byte to the datapath with a one-clock execute strobe. The result always goes to the implied accumulator in the datapath, so the sequencer never writes memory.

There are two addressing forms. In the first, a plain opcode takes its operand from the address held in a 16-bit pointer register. In the second, a prefix byte chooses one of two 16-bit index registers. The opcode follows the prefix, and then a displacement byte. The operand address is the chosen index register plus the sign-extended displacement. The sequencer spends a five-clock machine cycle forming that sum. The memory port has no handshake. It returns data in the same cycle as the address and never stalls, so there is no back-pressure, and every instruction runs to an exact, fixed T-state profile. The register values arrive on plain input pins from the register file.

Top module: `memop_seq`

## Requirements
- R1: A first byte of the form `10ooo110` (bits 7:6 = 10, bits 2:0 = 110) starts the pointer form. The operand read uses the address on `ptr_reg`, and `alu_op` carries bits 5:3 of the opcode.
- R2: A first byte of the form `11N11101` is a prefix. When the byte after it has the `10ooo110` form, the indexed form runs, with `idx0_reg` selected when bit 5 (N) is 0 and `idx1_reg` selected when N is 1.
- R3: In the indexed form, the third byte is a two's-complement displacement. The operand address is the selected index register plus the displacement sign-extended to 16 bits, wrapping modulo 65536.
- R4: The pointer form takes two machine cycles of 4 and 3 clocks, so `alu_go` rises 7 clocks after the first fetch clock.
- R5: The indexed form takes five machine cycles of 4, 4, 3, 5 and 3 clocks, so `alu_go` rises 19 clocks after the first fetch clock.
- R6: `pc` advances by one at the end of every opcode, prefix or displacement fetch. The pointer form therefore moves it by 1 and the indexed form by 3. `mem_addr` equals `pc` in every cycle other than the operand read.
- R7: `alu_go` is high for exactly one clock, in the cycle after the last clock of the operand read. In that cycle `alu_operand` holds the byte that was read and `alu_op` holds the operation.
- R8: An unprefixed byte that is not `10ooo110` is a no-operation of 4 clocks that moves `pc` by 1. A prefix followed by a byte that is not `10ooo110` is a no-operation of 8 clocks that moves `pc` by 2. Neither case raises `alu_go`, and fetch resumes after either one.
- R9: `mem_rd` is high in every fetch, displacement-read and operand-read clock. It is low in all 5 clocks of the address-add machine cycle.
- R10: While `rst_n` is low, `pc` equals the RESET_PC parameter (default 0), `m_num` and `t_num` are 1, and `alu_go` is 0. Fetching begins in the first clock after release.
- R11: `m_num` gives the current machine cycle, counting from 1 within an instruction: the operand read is machine cycle 2 in the pointer form and 5 in the indexed form. `t_num` counts the clocks within the machine cycle from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_reg | input | 16 | Pointer register used by the plain form |
| idx0_reg | input | 16 | Index register chosen by N = 0 |
| idx1_reg | input | 16 | Index register chosen by N = 1 |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| pc | output | 16 | Program counter |
| m_num | output | 3 | Current machine cycle number |
| t_num | output | 3 | Current T-state within the machine cycle |
| alu_go | output | 1 | One-clock execute strobe |
| alu_op | output | 3 | ALU operation field |
| alu_operand | output | 8 | Operand byte read from memory |

## Verification
The stimulus is a program of mixed instructions that the sequencer runs back to back. It includes the pointer form, both index registers, and positive, negative, maximum-positive and minus-one displacements. One of these sums wraps past 0xFFFF and separates a true modulo-65536 add from a carry-dropping or zero-extending one. Some instructions are preceded by an unprefixed no-operation or by a prefix with an unsupported opcode. These show whether those bytes take the right number of clocks and bytes, and whether they leak a spurious prefix into the next instruction. For every strobe, the test compares the clock count since the previous strobe, the program counter, the read address, the operand, the operation code, the number of read-free clocks and the machine-cycle number against values computed from the requirements. A reset in mid-run then shows that the sequencer restarts cleanly.

// File: rtl/memop_seq_pkg.sv
package memop_seq_pkg;

  typedef enum logic [2:0] {
    MC_FETCH = 3'd0,
    MC_OPC   = 3'd1,
    MC_DISP  = 3'd2,
    MC_ADD   = 3'd3,
    MC_READ  = 3'd4
  } mcyc_e;

  localparam int TW = 3;

  typedef struct packed {
    logic       prefix;
    logic       idx_sel;
    logic       alu_mem;
    logic [2:0] op;
  } dec_t;

  function automatic logic [TW-1:0] mc_len(input mcyc_e s);
    unique case (s)
      MC_FETCH: mc_len = 3'd4;
      MC_OPC:   mc_len = 3'd4;
      MC_DISP:  mc_len = 3'd3;
      MC_ADD:   mc_len = 3'd5;
      MC_READ:  mc_len = 3'd3;
      default:  mc_len = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/memop_seq_tcount.sv
module memop_seq_tcount #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] len,
  output logic [TW-1:0] t_out,
  output logic          last
);

  localparam logic [TW-1:0] T_ONE = TW'(1);

  logic [TW-1:0] t_q;

  assign last  = (t_q == len);
  assign t_out = t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= T_ONE;
    else if (last) t_q <= T_ONE;
    else           t_q <= t_q + T_ONE;
  end

  // R11: the T-state either restarts at 1 or steps up by one
  p_t_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (t_out != T_ONE) |-> (t_out == $past(t_out) + T_ONE));

  // R11: the T-state never passes the length of the current machine cycle
  p_t_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (t_out >= T_ONE) && (t_out <= len));

endmodule

// File: rtl/memop_seq_decode.sv
module memop_seq_decode
  import memop_seq_pkg::*;
(
  input  logic [7:0] byte_in,
  output dec_t       dec
);

  always_comb begin
    dec.prefix  = (byte_in[7:6] == 2'b11) && (byte_in[4:0] == 5'b11101);
    dec.idx_sel = byte_in[5];
    dec.alu_mem = (byte_in[7:6] == 2'b10) && (byte_in[2:0] == 3'b110);
    dec.op      = byte_in[5:3];
  end

endmodule

// File: rtl/memop_seq_ea.sv
module memop_seq_ea #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] ea
);

  localparam int XW = AW - DW;

  logic [AW-1:0] disp_sx;

  assign disp_sx = {{XW{disp[DW-1]}}, disp};
  assign ea      = base + disp_sx;

endmodule

// File: rtl/memop_seq.sv
module memop_seq
  import memop_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr_reg,
  input  logic [AW-1:0] idx0_reg,
  input  logic [AW-1:0] idx1_reg,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [2:0]    m_num,
  output logic [2:0]    t_num,
  output logic          alu_go,
  output logic [2:0]    alu_op,
  output logic [DW-1:0] alu_operand
);

  localparam logic [AW-1:0] PC_STEP = AW'(1);
  localparam logic [2:0]    M_ONE   = 3'd1;

  mcyc_e         state;
  logic [2:0]    m_cnt;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] disp_q;
  logic          idx_sel_q;
  logic [2:0]    op_q;
  logic [DW-1:0] operand_q;
  logic          go_q;

  logic [TW-1:0] t_cur;
  logic          t_last;
  dec_t          dec;
  logic [AW-1:0] idx_base;
  logic [AW-1:0] ea_sum;

  memop_seq_tcount #(.TW(TW)) u_tcount (
    .clk   (clk),
    .rst_n (rst_n),
    .len   (mc_len(state)),
    .t_out (t_cur),
    .last  (t_last)
  );

  memop_seq_decode u_decode (
    .byte_in (mem_rdata[7:0]),
    .dec     (dec)
  );

  assign idx_base = idx_sel_q ? idx1_reg : idx0_reg;

  memop_seq_ea #(.AW(AW), .DW(DW)) u_ea (
    .base (idx_base),
    .disp (disp_q),
    .ea   (ea_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MC_FETCH;
      m_cnt     <= M_ONE;
      pc_q      <= RESET_PC;
      ea_q      <= '0;
      disp_q    <= '0;
      idx_sel_q <= 1'b0;
      op_q      <= '0;
      operand_q <= '0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (t_last) begin
        unique case (state)
          MC_FETCH: begin
            pc_q <= pc_q + PC_STEP;
            if (dec.prefix) begin
              idx_sel_q <= dec.idx_sel;
              state     <= MC_OPC;
              m_cnt     <= 3'd2;
            end else if (dec.alu_mem) begin
              op_q  <= dec.op;
              ea_q  <= ptr_reg;
              state <= MC_READ;
              m_cnt <= 3'd2;
            end else begin
              m_cnt <= M_ONE;
            end
          end
          MC_OPC: begin
            pc_q <= pc_q + PC_STEP;
            if (dec.alu_mem) begin
              op_q  <= dec.op;
              state <= MC_DISP;
              m_cnt <= 3'd3;
            end else begin
              state <= MC_FETCH;
              m_cnt <= M_ONE;
            end
          end
          MC_DISP: begin
            pc_q   <= pc_q + PC_STEP;
            disp_q <= mem_rdata;
            state  <= MC_ADD;
            m_cnt  <= 3'd4;
          end
          MC_ADD: begin
            ea_q  <= ea_sum;
            state <= MC_READ;
            m_cnt <= 3'd5;
          end
          MC_READ: begin
            operand_q <= mem_rdata;
            go_q      <= 1'b1;
            state     <= MC_FETCH;
            m_cnt     <= M_ONE;
          end
          default: begin
            state <= MC_FETCH;
            m_cnt <= M_ONE;
          end
        endcase
      end
    end
  end

  assign mem_rd      = (state != MC_ADD);
  assign mem_addr    = (state == MC_READ) ? ea_q : pc_q;
  assign pc          = pc_q;
  assign m_num       = m_cnt;
  assign t_num       = t_cur;
  assign alu_go      = go_q;
  assign alu_op      = op_q;
  assign alu_operand = operand_q;

  // R9: no read strobe during the address-add machine cycle
  p_add_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_num == 3'd4) |-> !mem_rd);

  // R7: the execute strobe lasts a single clock
  p_go_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |=> !alu_go);

  // R7: the strobe coincides with the first clock of the next fetch
  p_go_at_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |-> (m_num == M_ONE && t_num == 3'd1 && mem_rd && mem_addr == pc));

  // R6: the program counter moves only after a clock with a read
  p_pc_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> $past(mem_rd));

  // R11: the machine-cycle number restarts at 1 or steps up by one
  p_m_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_num != $past(m_num)) |-> (m_num == M_ONE || m_num == $past(m_num) + 3'd1));

endmodule

// File: tb/memop_seq_bench.sv
`timescale 1ns/1ps
module memop_seq_bench;

  localparam int NV = 8;
  // fields: [14:13] lead-in (0 none, 1 prefix+bad, 2 bad byte), [12:11] form (0 ptr, 1 idx0, 2 idx1), [10:8] op, [7:0] disp
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 2'd0, 3'd0, 8'h00},
    {2'd0, 2'd1, 3'd2, 8'h05},
    {2'd0, 2'd2, 3'd3, 8'h7F},
    {2'd0, 2'd1, 3'd4, 8'h80},
    {2'd2, 2'd0, 3'd5, 8'h00},
    {2'd0, 2'd1, 3'd7, 8'hF0},
    {2'd1, 2'd2, 3'd6, 8'hFF},
    {2'd1, 2'd0, 3'd1, 8'h00}
  };
  localparam logic [15:0] PTR  = 16'h0300;
  localparam logic [15:0] IDX0 = 16'h0200;
  localparam logic [15:0] IDX1 = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, pc;
  logic        mem_rd, alu_go;
  logic [7:0]  mem_rdata, alu_operand;
  logic [2:0]  m_num, t_num, alu_op;
  logic [7:0]  mem [1024];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  assign mem_rdata = mem[mem_addr[9:0]];

  memop_seq u_memop_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_reg     (PTR),
    .idx0_reg    (IDX0),
    .idx1_reg    (IDX1),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_rdata   (mem_rdata),
    .pc          (pc),
    .m_num       (m_num),
    .t_num       (t_num),
    .alu_go      (alu_go),
    .alu_op      (alu_op),
    .alu_operand (alu_operand)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    int          wp;
    int          k;
    int          guard;
    int          cum_cyc;
    int          cum_pc;
    int          rd_low;
    int          max_t;
    logic [15:0] last_addr;
    logic [2:0]  last_m;
    logic        wd;

    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'hA5 ^ {6'd0, 2'(i >> 8)};
    for (int i = 0; i < 16'h60; i++) mem[i] = 8'h00;
    wp = 0;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][14:13] == 2'd1) begin mem[wp] = 8'hDD; mem[wp+1] = 8'h3E; wp += 2; end
      if (VEC[v][14:13] == 2'd2) begin mem[wp] = 8'h00; wp += 1; end
      if (VEC[v][12:11] == 2'd1) begin mem[wp] = 8'hDD; wp += 1; end
      if (VEC[v][12:11] == 2'd2) begin mem[wp] = 8'hFD; wp += 1; end
      mem[wp] = {2'b10, VEC[v][10:8], 3'b110}; wp += 1;
      if (VEC[v][12:11] != 2'd0) begin mem[wp] = VEC[v][7:0]; wp += 1; end
    end

    // R10: state held in reset
    repeat (2) @(negedge clk);
    chk("R10", "pc in reset", 32'(pc), 32'h0);
    chk("R10", "m_num in reset", 32'(m_num), 32'd1);
    chk("R10", "t_num in reset", 32'(t_num), 32'd1);
    chk("R10", "alu_go in reset", 32'(alu_go), 32'd0);
    rst_n = 1'b1;

    k = 0; guard = 0; cum_cyc = 0; cum_pc = 0; rd_low = 0; max_t = 0;
    last_addr = '0; last_m = '0; wd = 1'b0;
    while (k < NV && !wd) begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        wd = 1'b1;
        chk("R7", "watchdog before strobe", 32'd1, 32'd0);
      end else begin
        if (alu_go) begin
          logic [1:0]  pre;
          logic [1:0]  form;
          logic [15:0] ea;
          int          len;
          int          nb;
          pre  = VEC[k][14:13];
          form = VEC[k][12:11];
          len  = (form == 2'd0) ? 7 : 19;
          nb   = (form == 2'd0) ? 1 : 3;
          if (pre == 2'd1) begin len += 8; nb += 2; end
          if (pre == 2'd2) begin len += 4; nb += 1; end
          if (form == 2'd0)      ea = PTR;
          else if (form == 2'd1) ea = IDX0 + {{8{VEC[k][7]}}, VEC[k][7:0]};
          else                   ea = IDX1 + {{8{VEC[k][7]}}, VEC[k][7:0]};
          cum_cyc += len;
          cum_pc  += nb;
          chk((pre != 2'd0) ? "R8" : ((form == 2'd0) ? "R4" : "R5"), "strobe cycle", 32'(cyc), 32'(cum_cyc));
          chk("R6", "pc at strobe", 32'(pc), 32'(cum_pc));
          chk((form == 2'd0) ? "R1" : "R3", "operand address", 32'(last_addr), 32'(ea));
          chk((form == 2'd0) ? "R1" : "R2", "alu_op", 32'(alu_op), 32'(VEC[k][10:8]));
          chk("R7", "alu_operand", 32'(alu_operand), 32'(mem[ea[9:0]]));
          chk("R9", "clocks without read", 32'(rd_low), (form == 2'd0) ? 32'd0 : 32'd5);
          chk("R11", "m_num at operand read", 32'(last_m), (form == 2'd0) ? 32'd2 : 32'd5);
          chk("R11", "longest T count", 32'(max_t), (form == 2'd0) ? 32'd4 : 32'd5);
          k++;
          rd_low = 0;
          max_t = 0;
        end
        if (mem_rd) begin last_addr = mem_addr; last_m = m_num; end
        else rd_low++;
        if (int'(t_num) > max_t) max_t = int'(t_num);
      end
    end

    // R10: reset in mid-run, then the first instruction runs again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "pc after mid reset", 32'(pc), 32'h0);
    chk("R10", "alu_go after mid reset", 32'(alu_go), 32'd0);
    chk("R10", "t_num after mid reset", 32'(t_num), 32'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    guard = 0;
    last_addr = '0;
    while (!alu_go && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (!alu_go && mem_rd) last_addr = mem_addr;
    end
    chk("R4", "restart strobe cycle", 32'(cyc), 32'd7);
    chk("R1", "restart operand address", 32'(last_addr), 32'(PTR));
    @(negedge clk);
    chk("R7", "strobe drops after one clock", 32'(alu_go), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule